// File: doc/BRIEF.md
# Maskable BCD Time-of-Day Alarm

This block compares a running calendar against a programmed alarm word. The calendar gives seconds, minutes, hours with an afternoon indicator, and day of month, all in BCD. Software programs the alarm word over a simple word-addressed register bus. Any of the four fields can be marked "don't care". When the alarm is armed, the block evaluates the comparison on each one-second tick. On a hit it raises a sticky flag and, if the interrupt is allowed, an interrupt line.

The alarm word has no month or year, so a programmed day of month hits again every month. The intended software sequence is fixed: disarm the alarm, rewrite the alarm word, then arm it again. The alarm word is frozen while the alarm is armed.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After reset, the flag, the interrupt, the alarm word and both control bits are zero, and a read of every address returns zero.
- R2: The register addresses are 0 (alarm word), 1 (control), 2 (status, read-only) and 3 (clear, write-only, reads 0). The read data is registered and returns the register selected by the read address one cycle later. Alarm word bit 30 always reads 0. Control reads back only bit 8 (arm) and bit 12 (interrupt enable). Status bit 0 is the flag.
- R3: The alarm word layout is: seconds units 3:0 and tens 6:4; minutes units 11:8 and tens 14:12; hours units 19:16, tens 21:20 and afternoon bit 22; day units 27:24 and tens 29:28. A field matches when it equals the current value. The afternoon bit is part of the hours field.
- R4: Mask bits 7 (seconds), 15 (minutes), 23 (hours including the afternoon bit) and 31 (day) make their field match whatever the current value is.
- R5: The flag sets only on a cycle where sec_tick is high, the alarm is armed and all fields match. It becomes visible on the next cycle. A match without a tick has no effect.
- R6: While the alarm is disarmed, no tick or match sets the flag.
- R7: The flag stays set until a write to the clear address with bit 0 high. A clear write with bit 0 low leaves the flag set. A set and a clear in the same cycle leave the flag set.
- R8: alarm_irq always equals the flag ANDed with control bit 12, on the same cycle.
- R9: Writes to the alarm word are ignored while the alarm is armed.
- R10: Month and year are not compared, so the same day of month hits again after the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write word address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | ADDR_W | Read word address |
| bus_rdata | output | 32 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse per calendar second |
| now_sec | input | 7 | Current seconds, BCD tens 6:4, units 3:0 |
| now_min | input | 7 | Current minutes, BCD tens 6:4, units 3:0 |
| now_hour | input | 6 | Current hours, BCD tens 5:4, units 3:0 |
| now_pm | input | 1 | Current afternoon indicator |
| now_date | input | 6 | Current day of month, BCD tens 5:4, units 3:0 |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Flag gated by the interrupt enable |

## Verification
The checker monitors on every cycle that the interrupt equals the flag gated by the enable. It also checks that a rising flag always follows an armed tick with a match, that the flag holds without a clear, that a clear without a set drops it, and that the alarm word stays frozen while armed. The field layout, the mask bits, the afternoon bit, the monthly repeat and the register readback can only be shown by the bench. The bench sweeps seconds, minutes and days against decimal alarm values and encodes them to BCD itself.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_FIELDS = 4;
  localparam int ADR_ALARM  = 0;
  localparam int ADR_CTRL   = 1;
  localparam int ADR_STAT   = 2;
  localparam int ADR_CLR    = 3;
  localparam int ARM_BIT    = 8;
  localparam int IE_BIT     = 12;
  localparam logic [WORD_W-1:0] WORD_KEEP = 32'hBFFF_FFFF;

  function automatic int fld_lo(input int i);
    return 8 * i;
  endfunction

  function automatic int fld_w(input int i);
    return (i == 3) ? 6 : 7;
  endfunction

  function automatic int fld_mask(input int i);
    return (i == 3) ? 31 : 8 * i + 7;
  endfunction
endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  input  logic              flag,
  output logic [WORD_W-1:0] alarm_word,
  output logic              arm,
  output logic              ie,
  output logic              ie_nxt,
  output logic              clr_hit,
  output logic [WORD_W-1:0] bus_rdata
);
  logic wr_alarm, wr_ctrl;

  assign wr_alarm = bus_wr && (bus_addr == ADDR_W'(ADR_ALARM));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign clr_hit  = bus_wr && (bus_addr == ADDR_W'(ADR_CLR)) && bus_wdata[0];
  assign ie_nxt   = wr_ctrl ? bus_wdata[IE_BIT] : ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_word <= '0;
      arm        <= 1'b0;
      ie         <= 1'b0;
    end else begin
      if (wr_alarm && !arm) alarm_word <= bus_wdata & WORD_KEEP;
      if (wr_ctrl) arm <= bus_wdata[ARM_BIT];
      ie <= ie_nxt;
    end
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_raddr == ADDR_W'(ADR_ALARM)) rd_mux = alarm_word;
    else if (bus_raddr == ADDR_W'(ADR_CTRL)) begin
      rd_mux[ARM_BIT] = arm;
      rd_mux[IE_BIT]  = ie;
    end else if (bus_raddr == ADDR_W'(ADR_STAT)) rd_mux[0] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic [WORD_W-1:0] alarm_word,
  input  logic [WORD_W-1:0] now_word,
  output logic              match
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int LO = fld_lo(i);
    localparam int W  = fld_w(i);
    localparam int MB = fld_mask(i);
    assign hit[i] = alarm_word[MB] || (alarm_word[LO +: W] == now_word[LO +: W]);
  end

  assign match = &hit;
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic arm,
  input  logic match,
  input  logic clr_hit,
  input  logic ie_nxt,
  output logic flag,
  output logic irq
);
  logic flag_nxt;

  assign flag_nxt = (flag && !clr_hit) || (tick && arm && match);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt && ie_nxt;
    end
  end
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [31:0]       bus_rdata,
  input  logic              sec_tick,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic              now_pm,
  input  logic [5:0]        now_date,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  logic [WORD_W-1:0] alarm_word, now_word;
  logic arm, ie, ie_nxt, clr_hit, match;

  assign now_word = {2'b00, now_date, 1'b0, now_pm, now_hour,
                     1'b0, now_min, 1'b0, now_sec};

  bcd_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .flag(alarm_flag),
    .alarm_word(alarm_word), .arm(arm), .ie(ie), .ie_nxt(ie_nxt),
    .clr_hit(clr_hit), .bus_rdata(bus_rdata)
  );

  bcd_alarm_match u_match (
    .alarm_word(alarm_word), .now_word(now_word), .match(match)
  );

  bcd_alarm_flag u_flag (
    .clk(clk), .rst(rst), .tick(sec_tick), .arm(arm), .match(match),
    .clr_hit(clr_hit), .ie_nxt(ie_nxt), .flag(alarm_flag), .irq(alarm_irq)
  );
endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk (
  input logic        clk,
  input logic        rst,
  input logic        sec_tick,
  input logic        arm,
  input logic        ie,
  input logic        clr_hit,
  input logic        match,
  input logic [31:0] alarm_word,
  input logic        alarm_flag,
  input logic        alarm_irq
);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    alarm_irq == (alarm_flag && ie));

  p_set_cause_r5: assert property (@(posedge clk) disable iff (rst)
    !alarm_flag ##1 alarm_flag |-> $past(sec_tick && arm && match));

  p_no_set_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && !arm) |=> !alarm_flag);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !clr_hit) |=> alarm_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !(sec_tick && arm && match)) |=> !alarm_flag);

  p_word_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    arm |=> $stable(alarm_word));
endmodule

bind bcd_alarm_unit bcd_alarm_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .arm(arm), .ie(ie),
  .clr_hit(clr_hit), .match(match), .alarm_word(alarm_word),
  .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
);

// File: tb/tb_bcd_alarm_unit.sv
module tb_bcd_alarm_unit;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sec_tick = 1'b0, now_pm = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0;
  logic [5:0] now_hour = '0, now_date = '0;
  logic alarm_flag, alarm_irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference state, kept in decimal
  int a_s = 0, a_m = 0, a_h = 0, a_d = 0;
  bit a_pm = 0, k_s = 0, k_m = 0, k_h = 0, k_d = 0;
  bit e_arm = 0, e_ie = 0, e_flag = 0;
  logic [31:0] e_word = '0;

  always #4 clk = ~clk;

  bcd_alarm_unit dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_pm(now_pm), .now_date(now_date),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int s, int m, int h, bit p, int d,
                                      bit ms, bit mm, bit mh, bit md);
    logic [31:0] w;
    w = '0;
    w[3:0] = 4'(s % 10);   w[6:4] = 3'(s / 10);   w[7] = ms;
    w[11:8] = 4'(m % 10);  w[14:12] = 3'(m / 10); w[15] = mm;
    w[19:16] = 4'(h % 10); w[21:20] = 2'(h / 10); w[22] = p; w[23] = mh;
    w[27:24] = 4'(d % 10); w[29:28] = 2'(d / 10); w[31] = md;
    return w;
  endfunction

  task automatic bus_write(input int adr, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'(adr); bus_wdata = d;
    if (adr == 1) begin e_arm = d[8]; e_ie = d[12]; end
    if (adr == 3 && d[0]) e_flag = 0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic prog(int s, int m, int h, bit p, int d,
                      bit ms, bit mm, bit mh, bit md);
    logic [31:0] w;
    w = enc(s, m, h, p, d, ms, mm, mh, md);
    if (!e_arm) begin
      a_s = s; a_m = m; a_h = h; a_pm = p; a_d = d;
      k_s = ms; k_m = mm; k_h = mh; k_d = md; e_word = w;
    end
    bus_write(0, w);
  endtask

  task automatic bus_read(input int adr, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_raddr = 2'(adr);
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  function automatic bit ref_hit(int s, int m, int h, bit p, int d);
    return (k_s || s == a_s) && (k_m || m == a_m) &&
           (k_h || (h == a_h && p == a_pm)) && (k_d || d == a_d);
  endfunction

  // One-cycle tick (or no tick) at the given time; checks flag and irq after the edge
  task automatic step(int s, int m, int h, bit p, int d, bit tk, bit clr, string req);
    @(negedge clk);
    now_sec = {3'(s / 10), 4'(s % 10)};
    now_min = {3'(m / 10), 4'(m % 10)};
    now_hour = {2'(h / 10), 4'(h % 10)};
    now_pm = p;
    now_date = {2'(d / 10), 4'(d % 10)};
    sec_tick = tk;
    if (clr) begin bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h1; end
    e_flag = (e_flag && !clr) || (tk && e_arm && ref_hit(s, m, h, p, d));
    @(negedge clk);
    sec_tick = 1'b0; bus_wr = 1'b0;
    check(req, {31'b0, alarm_flag}, {31'b0, e_flag});
    check("R8", {31'b0, alarm_irq}, {31'b0, e_flag && e_ie});
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", {30'b0, alarm_irq, alarm_flag}, 32'h0);
    for (int a = 0; a < 4; a++) bus_read(a, 32'h0, "R1");

    // R2 readback and masking of unused bits
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, 32'hBFFF_FFFF, "R2");
    bus_write(1, 32'hFFFF_FFFF);
    e_arm = 0; bus_write(1, 32'h0);
    bus_read(1, 32'h0, "R2");
    bus_write(1, 32'h0000_1000);
    bus_read(1, 32'h0000_1000, "R2");
    bus_write(1, 32'h0);

    // R6 disarmed: matching time never sets the flag
    prog(30, 0, 0, 0, 15, 0, 0, 0, 0);
    bus_read(0, e_word, "R3");
    for (int s = 28; s < 33; s++) step(s, 0, 0, 0, 15, 1, 0, "R6");

    // R3 full sweep of seconds with all fields compared
    bus_write(1, 32'h0000_1100);
    for (int s = 0; s < 60; s++) begin
      step(s, 0, 0, 0, 15, 1, 0, "R3");
      if (e_flag) begin
        bus_read(2, 32'h1, "R2");
        bus_write(3, 32'h1);
      end
    end
    // R5 match without tick
    step(30, 0, 0, 0, 15, 0, 0, "R5");

    // R9 write while armed is ignored
    prog(45, 10, 11, 1, 3, 0, 0, 0, 0);
    bus_read(0, e_word, "R9");

    // R4 seconds masked, minutes sweep
    bus_write(1, 32'h0000_1000);
    prog(0, 41, 2, 0, 15, 1, 0, 0, 0);
    bus_write(1, 32'h0000_1100);
    for (int m = 0; m < 60; m++) begin
      step(7, m, 2, 0, 15, 1, 0, "R4");
      if (e_flag) bus_write(3, 32'h1);
    end

    // R3 afternoon bit is compared with hours
    bus_write(1, 32'h0);
    prog(0, 0, 5, 1, 15, 1, 1, 0, 1);
    bus_write(1, 32'h0000_1100);
    step(0, 0, 5, 0, 15, 1, 0, "R3");
    step(0, 0, 5, 1, 15, 1, 0, "R3");

    // R7 clear with bit 0 low is ignored, then proper clear, then set wins
    bus_write(3, 32'hFFFF_FFFE);
    step(0, 0, 4, 0, 15, 1, 0, "R7");
    bus_write(3, 32'h1);
    step(0, 0, 4, 0, 15, 1, 0, "R7");
    step(0, 0, 5, 1, 15, 1, 0, "R7");
    step(0, 0, 5, 1, 15, 1, 1, "R7");

    // R8 interrupt enable toggled while flag set
    bus_write(1, 32'h0000_0100);
    step(0, 0, 0, 0, 1, 0, 0, "R8");
    bus_write(1, 32'h0000_1100);
    step(0, 0, 0, 0, 1, 0, 0, "R8");
    bus_write(3, 32'h1);

    // R10 day of month only, repeats after clear; R4 hours mask
    bus_write(1, 32'h0);
    prog(0, 0, 0, 0, 12, 1, 1, 1, 0);
    bus_write(1, 32'h0000_1100);
    for (int rep = 0; rep < 2; rep++)
      for (int d = 1; d < 32; d++) begin
        step(33, 59, 23, rep[0], d, 1, 0, "R10");
        if (e_flag) bus_write(3, 32'h1);
      end

    // R4 every field masked: any tick sets
    bus_write(1, 32'h0);
    prog(0, 0, 0, 0, 1, 1, 1, 1, 1);
    bus_write(1, 32'h0000_0100);
    step(59, 59, 12, 1, 31, 1, 0, "R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule